// File: doc/BRIEF.md
# Asynchronous Bus Master with Timeout Monitor

This block runs one external read or write transfer at a time on behalf of a core. After the core raises a request, the block drives the address, a two-bit transfer-size code, the read/write line and an active-low address strobe. One clock later it asserts an active-low data strobe. The cycle then waits for the responding device to return a two-bit active-low acknowledge, which also reports whether that device is 8 or 16 bits wide. Whole-clock wait states are added until the acknowledge arrives. On a read, the data bus is captured one clock after the acknowledge is seen. Both strobes then drop.

Two external active-low inputs can abort a cycle: a bus-error line and a halt line. If both arrive together, bus error wins. An internal monitor can also abort the cycle with a bus error when no acknowledge comes within a selectable number of clocks. Acknowledge, bus error and halt are asynchronous to the block's clock, so each one passes through a two-flop synchronizer. The core receives a one-clock completion pulse along with an error flag, a halt flag, the reported port width and the read data.

Top module: `bus_xfer_master`

## Requirements
- R1: After reset, both strobes are high, bus_rw is high, bus_siz and bus_lane are 00, bus_addr is 0, bus_doe is 0, and busy and done are 0. done_err, done_halt, done_port8 and done_rdata are all 0.
- R2: A request sampled while the block is idle starts a cycle at that clock edge. bus_as_n goes low and the request's address is driven and held. bus_siz is 01 for a byte and 10 for a word. bus_rw is 1 for a read and 0 for a write. bus_ds_n goes low one clock after bus_as_n.
- R3: A cycle ended by acknowledge keeps bus_as_n low for at least three clocks. If the acknowledge is already present when the request is taken, the cycle lasts exactly three clocks.
- R4: While the synchronized acknowledge is 11 and nothing aborts the cycle, the strobes stay asserted with no upper bound.
- R5: Acknowledge, bus error and halt act on the cycle two clock edges after the edge that samples them. Acknowledge 10 reports an 8-bit port (done_port8=1). Codes 01 and 00 report a 16-bit port.
- R6: A read captures bus_din at the edge after the one that sees the acknowledge. A word from a 16-bit port returns the whole bus. A word from an 8-bit port returns bus bits 15:8 in bits 15:8 and zero below. A byte returns, in bits 7:0, bus bits 15:8 for an even address or an 8-bit port, and bus bits 7:0 for an odd address on a 16-bit port.
- R7: During a write, bus_doe is 1. bus_dout carries the word, or the byte copied onto both halves. Outside a write cycle, bus_doe and bus_dout are 0.
- R8: A bus error ends a waiting cycle with done_err=1 and done_halt=0. A halt alone ends it with done_halt=1 and done_err=0. Both together act as bus error alone.
- R9: With the monitor enabled, mon_sel 00/01/10/11 selects 64/32/16/8 clocks. A cycle with no response ends with done_err=1 after bus_as_n has been low for exactly that many clocks.
- R10: With the monitor disabled, no timeout ever ends a cycle.
- R11: An abort (bus error, halt or timeout) takes effect even if the acknowledge is seen at the same edge.
- R12: done is a one-clock pulse. The strobes are high for at least one clock between cycles. A request raised while busy is ignored.
- R13: While bus_as_n is low, bus_lane[1] (bits 15:8) is 1 for a word or an even address, and bus_lane[0] (bits 7:0) is 1 for a word or an odd address. Otherwise bus_lane is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a transfer (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| mon_en | input | 1 | Enable the timeout monitor for this cycle |
| mon_sel | input | 2 | Timeout select |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| done_err | output | 1 | Last cycle ended by bus error or timeout |
| done_halt | output | 1 | Last cycle ended by halt |
| done_port8 | output | 1 | Last acknowledge reported an 8-bit port |
| done_rdata | output | 16 | Last read result |
| bus_addr | output | ADDR_W | External address |
| bus_siz | output | 2 | Transfer size code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_lane | output | 2 | Active data lanes {high, low} |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 2 | Acknowledge and port width, active low |
| bus_berr_n | input | 1 | External bus error, active low |
| bus_halt_n | input | 1 | External halt, active low |

## Verification
The sensitive case is an acknowledge that reaches the state machine at the same edge as an abort. The abort can come from the monitor expiring or from a bus error or halt sampled together with the acknowledge. To provoke the monitor case, the bench drives the raw acknowledge exactly two edges before the eighth clock of a cycle with the 8-clock timeout selected. To provoke the external case, it drives the acknowledge and the abort line in the same clock. The bench then requires an error or halt ending, an 8-clock address strobe for the timeout case, and no new port-width report, with a clock-by-clock reference model confirming every output.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
   localparam int BXM_DW   = 16;
   localparam int BXM_LANE = 8;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_WAIT = 2'd2,
      PH_DATA = 2'd3
   } bxm_phase_e;

   localparam logic [1:0] SIZ_NONE  = 2'b00;
   localparam logic [1:0] SIZ_BYTE  = 2'b01;
   localparam logic [1:0] SIZ_WORD  = 2'b10;
   localparam logic [1:0] ACK_IDLE  = 2'b11;
   localparam logic [1:0] ACK_PORT8 = 2'b10;

   function automatic logic ack_is_port8(input logic [1:0] code);
      return code == ACK_PORT8;
   endfunction
endpackage

// File: rtl/bxm_sync.sv
module bxm_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bxm_sync: STAGES must be 2 or more");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bxm_sync: WIDTH must be positive");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [WIDTH-1:0] q;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= g_stage[s-1].q;
            end
         end
      end
   endgenerate

   assign q_sync = g_stage[STAGES-1].q;
endmodule

// File: rtl/bxm_monitor.sv
module bxm_monitor #(
   parameter int TMO_MAX = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic [1:0] sel,
   input  logic       en,
   input  logic       active,
   input  logic       check,
   output logic       expired
);
   localparam int CNT_W = $clog2(TMO_MAX);

   generate
      if ((TMO_MAX & (TMO_MAX - 1)) != 0) begin : g_bad_pow2
         $error("bxm_monitor: TMO_MAX must be a power of two");
      end
      if (TMO_MAX < 32) begin : g_bad_small
         $error("bxm_monitor: TMO_MAX must be at least 32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [1:0]       sel_q;
   logic             en_q;
   logic [CNT_W:0]   lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= 2'b00;
         en_q  <= 1'b0;
      end else begin
         if (arm) begin
            sel_q <= sel;
            en_q  <= en;
         end
         if (!active || !en_q) cnt <= '0;
         else                  cnt <= cnt + CNT_W'(1);
      end
   end

   assign lim     = (CNT_W+1)'(TMO_MAX) >> sel_q;
   assign expired = check && en_q && ({1'b0, cnt} == lim - (CNT_W+1)'(1));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && active) |-> ({1'b0, cnt} < lim)); // R9
   AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !active); // R9
endmodule

// File: rtl/bxm_lanes.sv
module bxm_lanes
   import bxm_pkg::*;
#(
   parameter bit REPLICATE_BYTE = 1'b1
) (
   input  logic              word,
   input  logic              a0,
   input  logic              port8,
   input  logic [BXM_DW-1:0] wdata,
   input  logic [BXM_DW-1:0] din,
   output logic [1:0]        lanes,
   output logic [BXM_DW-1:0] wbus,
   output logic [BXM_DW-1:0] rsel
);
   localparam int HI = BXM_DW - 1;
   localparam int LO = BXM_LANE;

   assign lanes = {word | ~a0, word | a0};

   generate
      if (REPLICATE_BYTE) begin : g_rep
         assign wbus = word ? wdata : {wdata[LO-1:0], wdata[LO-1:0]};
      end else begin : g_single
         assign wbus = word ? wdata :
                       (a0 ? {{LO{1'b0}}, wdata[LO-1:0]} : {wdata[LO-1:0], {LO{1'b0}}});
      end
   endgenerate

   always_comb begin
      if (word) begin
         rsel = port8 ? {din[HI:LO], {LO{1'b0}}} : din;
      end else if (port8 || !a0) begin
         rsel = {{LO{1'b0}}, din[HI:LO]};
      end else begin
         rsel = {{LO{1'b0}}, din[LO-1:0]};
      end
   end
endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
   import bxm_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int TMO_MAX     = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   input  logic              mon_en,
   input  logic [1:0]        mon_sel,
   output logic              busy,
   output logic              done,
   output logic              done_err,
   output logic              done_halt,
   output logic              done_port8,
   output logic [15:0]       done_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_siz,
   output logic              bus_rw,
   output logic              bus_as_n,
   output logic              bus_ds_n,
   output logic [1:0]        bus_lane,
   output logic [15:0]       bus_dout,
   output logic              bus_doe,
   input  logic [15:0]       bus_din,
   input  logic [1:0]        bus_ack_n,
   input  logic              bus_berr_n,
   input  logic              bus_halt_n
);
   localparam int SYNC_W = 4;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("bus_xfer_master: ADDR_W must be positive");
      end
      if (BXM_DW != 16) begin : g_bad_dw
         $error("bus_xfer_master: data bus must be 16 bits");
      end
   endgenerate

   bxm_phase_e        ph;
   logic              wr_q, word_q;
   logic [ADDR_W-1:0] addr_q;
   logic [15:0]       wd_q;
   logic [SYNC_W-1:0] sync_q;
   logic [1:0]        s_ack_n;
   logic              s_berr_n, s_halt_n;
   logic              active, waiting, tmo_exp;
   logic              berr_hit, halt_hit, ack_hit;
   logic [1:0]        lanes_raw;
   logic [15:0]       wbus, rsel;

   bxm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({bus_halt_n, bus_berr_n, bus_ack_n}),
      .q_sync  (sync_q)
   );
   assign s_ack_n  = sync_q[1:0];
   assign s_berr_n = sync_q[2];
   assign s_halt_n = sync_q[3];

   assign active  = (ph != PH_IDLE);
   assign waiting = (ph == PH_WAIT);

   bxm_monitor #(.TMO_MAX(TMO_MAX)) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     ((ph == PH_IDLE) && req_valid),
      .sel     (mon_sel),
      .en      (mon_en),
      .active  ((ph == PH_ADDR) || waiting),
      .check   (waiting),
      .expired (tmo_exp)
   );

   bxm_lanes #(.REPLICATE_BYTE(1'b1)) u_lanes (
      .word  (word_q),
      .a0    (addr_q[0]),
      .port8 (done_port8),
      .wdata (wd_q),
      .din   (bus_din),
      .lanes (lanes_raw),
      .wbus  (wbus),
      .rsel  (rsel)
   );

   assign berr_hit = !s_berr_n || tmo_exp;
   assign halt_hit = !s_halt_n;
   assign ack_hit  = (s_ack_n != ACK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         wr_q       <= 1'b0;
         word_q     <= 1'b0;
         addr_q     <= '0;
         wd_q       <= '0;
         done       <= 1'b0;
         done_err   <= 1'b0;
         done_halt  <= 1'b0;
         done_port8 <= 1'b0;
         done_rdata <= '0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (req_valid) begin
                  ph     <= PH_ADDR;
                  wr_q   <= req_write;
                  word_q <= req_word;
                  addr_q <= req_addr;
                  wd_q   <= req_wdata;
               end
            end
            PH_ADDR: ph <= PH_WAIT;
            PH_WAIT: begin
               if (berr_hit) begin
                  ph        <= PH_IDLE;
                  done      <= 1'b1;
                  done_err  <= 1'b1;
                  done_halt <= 1'b0;
               end else if (halt_hit) begin
                  ph        <= PH_IDLE;
                  done      <= 1'b1;
                  done_err  <= 1'b0;
                  done_halt <= 1'b1;
               end else if (ack_hit) begin
                  ph         <= PH_DATA;
                  done_port8 <= ack_is_port8(s_ack_n);
               end
            end
            PH_DATA: begin
               ph        <= PH_IDLE;
               done      <= 1'b1;
               done_err  <= 1'b0;
               done_halt <= 1'b0;
               if (!wr_q) done_rdata <= rsel;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy     = active;
   assign bus_as_n = !active;
   assign bus_ds_n = !(waiting || (ph == PH_DATA));
   assign bus_addr = active ? addr_q : '0;
   assign bus_siz  = !active ? SIZ_NONE : (word_q ? SIZ_WORD : SIZ_BYTE);
   assign bus_rw   = active ? !wr_q : 1'b1;
   assign bus_lane = active ? lanes_raw : 2'b00;
   assign bus_doe  = active && wr_q;
   assign bus_dout = bus_doe ? wbus : '0;

   AST_DS_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ds_n) |-> $past(!bus_as_n)); // R2
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr)); // R2
   AST_MIN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_as_n) |-> ($past(!bus_as_n, 2) && $past(!bus_as_n, 3))); // R3
   AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_as_n) |=> bus_as_n); // R12
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(done_err && done_halt)); // R8
   AST_BERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !s_berr_n) |=> (done && done_err && !done_halt)); // R11
endmodule

// File: tb/bus_xfer_master_bench.sv
module bus_xfer_master_bench;
   localparam int AW  = 24;
   localparam int TMO = 64;

   logic clk = 1'b0;
   logic rst_n;
   always #10 clk = ~clk;

   logic          req_valid = 0, req_write = 0, req_word = 0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic          mon_en = 0;
   logic [1:0]    mon_sel = 2'b00;
   logic [15:0]   bus_din = '0;
   logic [1:0]    bus_ack_n = 2'b11;
   logic          bus_berr_n = 1, bus_halt_n = 1;
   logic          busy, done, done_err, done_halt, done_port8;
   logic [15:0]   done_rdata, bus_dout;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_siz, bus_lane;
   logic          bus_rw, bus_as_n, bus_ds_n, bus_doe;

   bus_xfer_master #(.ADDR_W(AW), .TMO_MAX(TMO), .SYNC_STAGES(2)) u_bus_xfer_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .mon_en(mon_en), .mon_sel(mon_sel), .busy(busy), .done(done),
      .done_err(done_err), .done_halt(done_halt), .done_port8(done_port8),
      .done_rdata(done_rdata), .bus_addr(bus_addr), .bus_siz(bus_siz),
      .bus_rw(bus_rw), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
      .bus_lane(bus_lane), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din), .bus_ack_n(bus_ack_n), .bus_berr_n(bus_berr_n),
      .bus_halt_n(bus_halt_n));

   int checks = 0, fails = 0;
   bit cmp_en = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // behavioural reference model
   int          m_ph = 0, m_cnt = 0;
   bit          m_wr, m_word, m_en, m_done, m_err, m_hlt, m_p8;
   logic [1:0]  m_sel;
   logic [AW-1:0] m_addr;
   logic [15:0] m_wd, m_rd;
   logic [1:0]  h_ack [2];
   logic        h_berr [2], h_halt [2];

   always @(posedge clk) begin
      logic [1:0] s_ack;
      logic s_berr, s_halt;
      int lim;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_done = 0; m_err = 0; m_hlt = 0; m_p8 = 0;
         m_rd = '0; m_wr = 0; m_word = 0; m_addr = '0; m_wd = '0; m_en = 0; m_sel = 0;
         h_ack[0] = 2'b11; h_ack[1] = 2'b11;
         h_berr[0] = 1; h_berr[1] = 1; h_halt[0] = 1; h_halt[1] = 1;
      end else begin
         s_ack = h_ack[1]; s_berr = h_berr[1]; s_halt = h_halt[1];
         h_ack[1] = h_ack[0]; h_ack[0] = bus_ack_n;
         h_berr[1] = h_berr[0]; h_berr[0] = bus_berr_n;
         h_halt[1] = h_halt[0]; h_halt[0] = bus_halt_n;
         m_done = 0;
         case (m_ph)
            0: if (req_valid) begin
                  m_ph = 1; m_cnt = 0; m_wr = req_write; m_word = req_word;
                  m_addr = req_addr; m_wd = req_wdata; m_en = mon_en; m_sel = mon_sel;
               end
            1: begin m_ph = 2; m_cnt++; end
            2: begin
                  lim = TMO >> m_sel;
                  if (!s_berr || (m_en && m_cnt == lim - 1)) begin
                     m_ph = 0; m_done = 1; m_err = 1; m_hlt = 0;
                  end else if (!s_halt) begin
                     m_ph = 0; m_done = 1; m_err = 0; m_hlt = 1;
                  end else if (s_ack != 2'b11) begin
                     m_p8 = (s_ack == 2'b10); m_ph = 3;
                  end else m_cnt++;
               end
            default: begin
                  m_ph = 0; m_done = 1; m_err = 0; m_hlt = 0;
                  if (!m_wr) begin
                     if (m_word) m_rd = m_p8 ? {bus_din[15:8], 8'h00} : bus_din;
                     else if (m_p8 || !m_addr[0]) m_rd = {8'h00, bus_din[15:8]};
                     else m_rd = {8'h00, bus_din[7:0]};
                  end
               end
         endcase
      end
   end

   // AS-low length and last completion flags, observed at the ports
   int as_run = 0, last_len = 0;
   bit got_err, got_hlt, got_p8;
   logic [15:0] got_rd;

   always @(negedge clk) begin
      bit act;
      if (cmp_en) begin
         act = (m_ph != 0);
         chk("R2 bus_as_n", bus_as_n, !act);
         chk("R2 bus_ds_n", bus_ds_n, !(m_ph == 2 || m_ph == 3));
         chk("R2 bus_siz", bus_siz, !act ? 2'b00 : (m_word ? 2'b10 : 2'b01));
         chk("R2 bus_rw", bus_rw, act ? !m_wr : 1'b1);
         chk("R2 bus_addr", bus_addr, act ? m_addr : '0);
         chk("R13 bus_lane", bus_lane, act ? {m_word | ~m_addr[0], m_word | m_addr[0]} : 2'b00);
         chk("R7 bus_doe", bus_doe, act && m_wr);
         chk("R7 bus_dout", bus_dout, (act && m_wr) ? (m_word ? m_wd : {m_wd[7:0], m_wd[7:0]}) : 16'h0);
         chk("R12 busy", busy, act);
         chk("R12 done", done, m_done);
         chk("R8 done_err", done_err, m_err);
         chk("R8 done_halt", done_halt, m_hlt);
         chk("R5 done_port8", done_port8, m_p8);
         chk("R6 done_rdata", done_rdata, m_rd);
      end
      if (!bus_as_n) as_run++;
      else if (as_run > 0) begin last_len = as_run; as_run = 0; end
      if (done) begin got_err = done_err; got_hlt = done_halt; got_p8 = done_port8; got_rd = done_rdata; end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic start(input bit w, input bit wd, input logic [AW-1:0] a,
                        input logic [15:0] d, input bit en, input logic [1:0] sel);
      @(negedge clk);
      req_valid = 1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
      mon_en = en; mon_sel = sel;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_done_release();
      for (int i = 0; i < 400 && !done; i++) @(negedge clk);
      @(negedge clk);
      bus_ack_n = 2'b11; bus_berr_n = 1; bus_halt_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic respond(input int k, input logic [1:0] ack, input bit be, input bit ha);
      repeat (k) @(negedge clk);
      bus_ack_n = ack; bus_berr_n = be; bus_halt_n = ha;
   endtask

   initial begin
      rst_n = 1;
      #1 rst_n = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 as_n", bus_as_n, 1); chk("R1 ds_n", bus_ds_n, 1);
      chk("R1 busy", busy, 0); chk("R1 done", done, 0);
      chk("R1 siz", bus_siz, 0); chk("R1 doe", bus_doe, 0);
      chk("R1 rdata", done_rdata, 0); chk("R1 rw", bus_rw, 1);
      rst_n = 1; cmp_en = 1;
      repeat (2) @(negedge clk);

      // word read, 16-bit port; extra request while busy (R12)
      bus_din = 16'hA55A;
      start(0, 1, 24'h001000, 16'h0, 0, 2'b00);
      req_valid = 1; req_addr = 24'h00BEEF;
      @(negedge clk);
      req_valid = 0;
      chk("R12 busy request ignored", bus_addr, 24'h001000);
      respond(0, 2'b01, 1, 1);
      wait_done_release();
      chk("R6 word read", got_rd, 16'hA55A);
      chk("R5 port16", got_p8, 0);

      // byte read, odd address, 16-bit port
      bus_din = 16'h12C3;
      start(0, 0, 24'h000201, 16'h0, 0, 2'b00);
      respond(2, 2'b00, 1, 1);
      wait_done_release();
      chk("R6 odd byte", got_rd, 16'h00C3);
      chk("R5 code 00 is 16-bit", got_p8, 0);

      // byte read, 8-bit port, odd address -> upper lane
      bus_din = 16'h7E11;
      start(0, 0, 24'h000203, 16'h0, 0, 2'b00);
      respond(1, 2'b10, 1, 1);
      wait_done_release();
      chk("R6 port8 byte", got_rd, 16'h007E);
      chk("R5 port8", got_p8, 1);

      // word write, then byte write
      start(1, 1, 24'h000400, 16'h1234, 0, 2'b00);
      respond(0, 2'b01, 1, 1);
      wait_done_release();
      chk("R7 write ok", got_err, 0);
      start(1, 0, 24'h000401, 16'h00AB, 0, 2'b00);
      respond(3, 2'b10, 1, 1);
      wait_done_release();
      chk("R7 byte write rdata untouched", got_rd, 16'h007E);

      // minimum length: acknowledge already present
      bus_ack_n = 2'b01;
      start(0, 1, 24'h000010, 16'h0, 0, 2'b00);
      wait_done_release();
      chk("R3 minimum length", last_len, 3);

      // unbounded wait with monitor disabled
      start(0, 1, 24'h000020, 16'h0, 0, 2'b11);
      repeat (200) @(negedge clk);
      chk("R4 still waiting", bus_as_n, 0);
      chk("R10 no timeout", busy, 1);
      respond(0, 2'b11, 0, 1);
      wait_done_release();
      chk("R8 berr ends", got_err, 1);

      // timeouts for every select value
      for (int s = 0; s < 4; s++) begin
         start(0, 1, 24'h000030, 16'h0, 1, 2'(s));
         wait_done_release();
         chk("R9 timeout length", last_len, 64 >> s);
         chk("R9 timeout error", got_err, 1);
      end

      // halt alone, then bus error and halt together
      start(0, 1, 24'h000040, 16'h0, 0, 2'b00);
      respond(1, 2'b11, 1, 0);
      wait_done_release();
      chk("R8 halt flag", got_hlt, 1);
      chk("R8 halt no err", got_err, 0);
      start(0, 1, 24'h000042, 16'h0, 0, 2'b00);
      respond(1, 2'b11, 0, 0);
      wait_done_release();
      chk("R8 both -> err", got_err, 1);
      chk("R8 both -> no halt", got_hlt, 0);

      // acknowledge seen at the same edge as timeout
      start(0, 1, 24'h000050, 16'h0, 1, 2'b11);
      respond(5, 2'b10, 1, 1);
      wait_done_release();
      chk("R11 timeout beats ack", got_err, 1);
      chk("R11 timeout length", last_len, 8);
      chk("R11 no port report", got_p8, 0);

      // acknowledge and halt in the same clock
      start(0, 1, 24'h000060, 16'h0, 0, 2'b00);
      respond(1, 2'b10, 1, 0);
      wait_done_release();
      chk("R11 halt beats ack", got_hlt, 1);

      summary();
      $finish;
   end
endmodule